// File: doc/BRIEF.md
# Outbound Mailbox Read Handler

This block hands a response object from a private SRAM window to a requester, one 32-bit word at a time, through a single data register. Firmware sets the start and inclusive end byte addresses of the window and the object length in words. It then pulses a start strobe. If the length fits the window, the handler loads its read pointer with the window start, raises a ready flag and flags an interrupt.

The requester reads the data register to get the word at the read pointer. A read never moves the pointer. A write of any value with all byte lanes enabled acknowledges that word, advances the pointer by one word and counts the remaining length down. Ready drops once the last word has been acknowledged. While ready is low, reads return zero and writes do nothing.

An abort strobe ends the transfer at any point. A bad length, a bad window or a partial-width write sets a sticky error flag.

Top module: `obx_read_handler`

## Requirements
- R1: A start pulse while ready is low, with a valid configuration, loads the read pointer with the window start (the two low address bits forced to zero) and the remaining count with the size, and sets ready on the next cycle.
- R2: While ready is high, a read pulse returns the SRAM word at the read pointer one cycle later, with `rvalid_o` high. The pointer and the count do not change.
- R3: While ready is high, a write pulse with all four byte enables set acknowledges the current word: the pointer grows by 4 and the remaining count drops by 1.
- R4: Acknowledging the final word clears ready, leaves the remaining count at 0 and leaves the pointer one word past the last word read. Ready is never high with a remaining count of 0.
- R5: While ready is low, a read returns zero with `rvalid_o` high, and a write changes neither the pointer, the count nor the error flag.
- R6: Each rise of ready sets the interrupt status on the following cycle. The status holds until an `intr_clr_i` pulse clears it; a set in the same cycle as a clear wins.
- R7: A start with a size of 0, a size above 1024, a size above the window length in words, or a window end below its start sets the error flag and leaves ready low.
- R8: A write while ready is high with any byte enable clear is ignored (pointer and count unchanged) and sets the error flag.
- R9: An abort pulse clears ready, the remaining count and the error flag, and resets the read pointer to the window start. It takes priority over every other input in the same cycle.
- R10: A start pulse while ready is high is ignored: the pointer and count keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base_i | input | AW | Window start byte address (low 2 bits ignored) |
| cfg_limit_i | input | AW | Inclusive window end byte address (low 2 bits ignored) |
| cfg_size_i | input | SIZE_W | Object length in 32-bit words |
| start_i | input | 1 | Pulse: make the configured object available |
| abort_i | input | 1 | Pulse: cancel the transfer |
| req_rd_i | input | 1 | Requester read of the data register |
| req_wr_i | input | 1 | Requester write (acknowledge) of the data register |
| req_be_i | input | DW/8 | Byte enables of the requester write |
| rdata_o | output | DW | Read response data |
| rvalid_o | output | 1 | Read response valid, one cycle after `req_rd_i` |
| sram_req_o | output | 1 | SRAM read request |
| sram_addr_o | output | AW | SRAM byte address |
| sram_rdata_i | input | DW | SRAM read data, one cycle after the request |
| ready_o | output | 1 | Object word available |
| intr_o | output | 1 | Interrupt status, set on a rise of ready |
| intr_clr_i | input | 1 | Pulse: clear the interrupt status |
| err_o | output | 1 | Sticky error flag |
| rd_ptr_o | output | AW | Current read pointer (byte address) |
| remain_o | output | SIZE_W | Words still to be acknowledged |

## Verification
The hardest state to reach is the end of the longest legal object, where the length exactly equals the window. Getting there needs a full walk of acknowledgements, and the last word must still come back before ready falls. The bench sets the window to eight words and starts an eight-word object. It acknowledges seven words, reads the last word through the scoreboard, then sends the final acknowledgement and checks where the pointer settles. Each rejected configuration is followed by an abort, so that the next case starts with the error flag clear.

// File: rtl/obx_pkg.sv
package obx_pkg;

    localparam int WORD_BYTES = 4;
    localparam int WORD_SHIFT = 2;

    // Outcome of checking a firmware configuration at start time
    typedef enum logic [1:0] {
        CFG_OK         = 2'd0,
        CFG_EMPTY      = 2'd1,
        CFG_TOO_BIG    = 2'd2,
        CFG_BAD_WINDOW = 2'd3
    } cfg_verdict_e;

    function automatic logic verdict_ok(cfg_verdict_e v);
        return v == CFG_OK;
    endfunction

endpackage

// File: rtl/obx_cfg_check.sv
module obx_cfg_check
    import obx_pkg::*;
#(
    parameter int AW        = 32,
    parameter int SIZE_W    = 11,
    parameter int MAX_WORDS = 1024
) (
    input  logic [AW-1:0]     base_i,
    input  logic [AW-1:0]     limit_i,
    input  logic [SIZE_W-1:0] size_i,
    output cfg_verdict_e      verdict_o
);
    localparam int WW = AW - WORD_SHIFT;

    logic [WW-1:0] base_w, limit_w;
    logic [WW:0]   span_words;
    logic [WW:0]   size_ext;
    logic [WORD_SHIFT*2-1:0] unused_low_bits;

    assign base_w          = base_i[AW-1:WORD_SHIFT];
    assign limit_w         = limit_i[AW-1:WORD_SHIFT];
    assign unused_low_bits = {base_i[WORD_SHIFT-1:0], limit_i[WORD_SHIFT-1:0]};
    assign span_words      = {1'b0, limit_w} - {1'b0, base_w} + {{WW{1'b0}}, 1'b1};
    assign size_ext        = {{(WW+1-SIZE_W){1'b0}}, size_i};

    always_comb begin
        if (size_i == '0)
            verdict_o = CFG_EMPTY;
        else if (limit_w < base_w)
            verdict_o = CFG_BAD_WINDOW;
        else if (size_i > SIZE_W'(MAX_WORDS) || size_ext > span_words)
            verdict_o = CFG_TOO_BIG;
        else
            verdict_o = CFG_OK;
    end
endmodule

// File: rtl/obx_walker.sv
module obx_walker
    import obx_pkg::*;
#(
    parameter int AW     = 32,
    parameter int SIZE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              ack_i,
    input  logic              bad_be_i,
    input  cfg_verdict_e      verdict_i,
    input  logic [AW-1:0]     base_i,
    input  logic [SIZE_W-1:0] size_i,
    output logic [AW-1:0]     ptr_o,
    output logic [SIZE_W-1:0] remain_o,
    output logic              ready_o,
    output logic              err_o
);
    logic [AW-1:0]     base_al;
    logic [AW-1:0]     ptr_q;
    logic [SIZE_W-1:0] remain_q;
    logic              ready_q, err_q;

    assign base_al = {base_i[AW-1:WORD_SHIFT], {WORD_SHIFT{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            remain_q <= '0;
            ready_q  <= 1'b0;
            err_q    <= 1'b0;
        end else if (abort_i) begin
            ptr_q    <= base_al;
            remain_q <= '0;
            ready_q  <= 1'b0;
            err_q    <= 1'b0;
        end else if (ready_q) begin
            if (ack_i) begin
                ptr_q    <= ptr_q + AW'(WORD_BYTES);
                remain_q <= remain_q - SIZE_W'(1);
                if (remain_q == SIZE_W'(1))
                    ready_q <= 1'b0;
            end else if (bad_be_i) begin
                err_q <= 1'b1;
            end
        end else if (start_i) begin
            if (verdict_ok(verdict_i)) begin
                ptr_q    <= base_al;
                remain_q <= size_i;
                ready_q  <= 1'b1;
                err_q    <= 1'b0;
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    assign ptr_o    = ptr_q;
    assign remain_o = remain_q;
    assign ready_o  = ready_q;
    assign err_o    = err_q;
endmodule

// File: rtl/obx_intr.sv
module obx_intr (
    input  logic clk,
    input  logic rst,
    input  logic ready_i,
    input  logic clr_i,
    output logic intr_o
);
    logic ready_q, status_q, rise;

    assign rise = ready_i & ~ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q  <= 1'b0;
            status_q <= 1'b0;
        end else begin
            ready_q <= ready_i;
            if (rise)
                status_q <= 1'b1;
            else if (clr_i)
                status_q <= 1'b0;
        end
    end

    assign intr_o = status_q;
endmodule

// File: rtl/obx_read_handler.sv
module obx_read_handler
    import obx_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int SIZE_W    = 11,
    parameter int MAX_WORDS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     cfg_base_i,
    input  logic [AW-1:0]     cfg_limit_i,
    input  logic [SIZE_W-1:0] cfg_size_i,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              req_rd_i,
    input  logic              req_wr_i,
    input  logic [DW/8-1:0]   req_be_i,
    output logic [DW-1:0]     rdata_o,
    output logic              rvalid_o,
    output logic              sram_req_o,
    output logic [AW-1:0]     sram_addr_o,
    input  logic [DW-1:0]     sram_rdata_i,
    output logic              ready_o,
    output logic              intr_o,
    input  logic              intr_clr_i,
    output logic              err_o,
    output logic [AW-1:0]     rd_ptr_o,
    output logic [SIZE_W-1:0] remain_o
);
    localparam int BE_W = DW / 8;

    cfg_verdict_e      verdict;
    logic              ready, full_word, ack, bad_be;
    logic [AW-1:0]     ptr;
    logic              rvalid_q, hit_q;

    assign full_word = (req_be_i == {BE_W{1'b1}});
    assign ack       = req_wr_i & ready & full_word;
    assign bad_be    = req_wr_i & ready & ~full_word;

    obx_cfg_check #(
        .AW(AW), .SIZE_W(SIZE_W), .MAX_WORDS(MAX_WORDS)
    ) u_cfg (
        .base_i   (cfg_base_i),
        .limit_i  (cfg_limit_i),
        .size_i   (cfg_size_i),
        .verdict_o(verdict)
    );

    obx_walker #(
        .AW(AW), .SIZE_W(SIZE_W)
    ) u_walk (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .abort_i  (abort_i),
        .ack_i    (ack),
        .bad_be_i (bad_be),
        .verdict_i(verdict),
        .base_i   (cfg_base_i),
        .size_i   (cfg_size_i),
        .ptr_o    (ptr),
        .remain_o (remain_o),
        .ready_o  (ready),
        .err_o    (err_o)
    );

    obx_intr u_intr (
        .clk    (clk),
        .rst    (rst),
        .ready_i(ready),
        .clr_i  (intr_clr_i),
        .intr_o (intr_o)
    );

    // Read path: fetch on demand, answer one cycle later
    assign sram_req_o  = req_rd_i & ready;
    assign sram_addr_o = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            hit_q    <= 1'b0;
        end else begin
            rvalid_q <= req_rd_i;
            hit_q    <= req_rd_i & ready;
        end
    end

    assign rdata_o  = hit_q ? sram_rdata_i : '0;
    assign rvalid_o = rvalid_q;
    assign ready_o  = ready;
    assign rd_ptr_o = ptr;
endmodule

// File: rtl/obx_read_handler_chk.sv
module obx_read_handler_chk #(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int SIZE_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [AW-1:0]     cfg_base_i,
    input logic [AW-1:0]     cfg_limit_i,
    input logic [SIZE_W-1:0] cfg_size_i,
    input logic              start_i,
    input logic              abort_i,
    input logic              req_rd_i,
    input logic              req_wr_i,
    input logic [DW/8-1:0]   req_be_i,
    input logic [DW-1:0]     rdata_o,
    input logic              rvalid_o,
    input logic              sram_req_o,
    input logic [AW-1:0]     sram_addr_o,
    input logic [DW-1:0]     sram_rdata_i,
    input logic              ready_o,
    input logic              intr_o,
    input logic              intr_clr_i,
    input logic              err_o,
    input logic [AW-1:0]     rd_ptr_o,
    input logic [SIZE_W-1:0] remain_o
);
    // R2
    read_no_advance_chk: assert property (@(posedge clk) disable iff (rst)
        ready_o && req_rd_i && !req_wr_i && !abort_i |=> $stable(rd_ptr_o) && rvalid_o);

    // R3
    ack_advance_chk: assert property (@(posedge clk) disable iff (rst)
        ready_o && req_wr_i && (&req_be_i) && !abort_i
        |=> rd_ptr_o == $past(rd_ptr_o) + AW'(4) && remain_o == $past(remain_o) - SIZE_W'(1));

    // R4
    ready_has_words_chk: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> remain_o != '0);

    // R5
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        req_rd_i && !ready_o |=> rvalid_o && rdata_o == '0);

    // R5
    idle_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        !ready_o && req_wr_i && !start_i && !abort_i |=> $stable(rd_ptr_o) && $stable(err_o));

    // R6
    rise_sets_intr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |=> intr_o);

    // R7
    empty_object_chk: assert property (@(posedge clk) disable iff (rst)
        !ready_o && start_i && !abort_i && cfg_size_i == '0 |=> err_o && !ready_o);

    // R9
    abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> !ready_o && remain_o == '0 && !err_o);
endmodule

bind obx_read_handler obx_read_handler_chk #(.AW(AW), .DW(DW), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/obx_read_handler_bench.sv
`timescale 1ns/1ps
module obx_read_handler_bench;
    localparam int AW = 32, DW = 32, SIZE_W = 11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [AW-1:0]     cfg_base = '0, cfg_limit = '0;
    logic [SIZE_W-1:0] cfg_size = '0;
    logic              start = 0, abort = 0, rd = 0, wr = 0, clr = 0;
    logic [3:0]        be = 4'hF;
    logic [DW-1:0]     rdata, sram_rdata;
    logic              rvalid, sram_req, ready, intr, err;
    logic [AW-1:0]     sram_addr, rd_ptr;
    logic [SIZE_W-1:0] remain;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] mem [0:255];

    always #2 clk = ~clk;

    obx_read_handler u_obx_read_handler (
        .clk(clk), .rst(rst), .cfg_base_i(cfg_base), .cfg_limit_i(cfg_limit),
        .cfg_size_i(cfg_size), .start_i(start), .abort_i(abort),
        .req_rd_i(rd), .req_wr_i(wr), .req_be_i(be), .rdata_o(rdata), .rvalid_o(rvalid),
        .sram_req_o(sram_req), .sram_addr_o(sram_addr), .sram_rdata_i(sram_rdata),
        .ready_o(ready), .intr_o(intr), .intr_clr_i(clr), .err_o(err),
        .rd_ptr_o(rd_ptr), .remain_o(remain));

    initial for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + 32'(i * 7);

    always @(posedge clk) if (sram_req) sram_rdata <= mem[sram_addr[9:2]];

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: push expectation, issue read
    task automatic do_read(logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk) rd = 1;
        @(negedge clk) rd = 0;
    endtask

    task automatic do_write(logic [3:0] lanes);
        @(negedge clk) begin wr = 1; be = lanes; end
        @(negedge clk) begin wr = 0; be = 4'hF; end
    endtask

    task automatic do_start(logic [31:0] b, logic [31:0] l, int s);
        @(negedge clk) begin cfg_base = b; cfg_limit = l; cfg_size = SIZE_W'(s); start = 1; end
        @(negedge clk) start = 0;
    endtask

    task automatic pulse_abort();
        @(negedge clk) abort = 1;
        @(negedge clk) abort = 0;
    endtask

    // Monitor: compare every response against the scoreboard
    initial forever begin
        @(negedge clk);
        if (rvalid) begin
            if (exp_q.size() == 0) check("R2 unexpected response", rdata, 32'hx);
            else check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R5 reset ready", 32'(ready), 0);
        check("R5 reset err", 32'(err), 0);
        check("R6 reset intr", 32'(intr), 0);
        check("R5 reset ptr", rd_ptr, 0);
        do_read(0, "R5 idle read zero");
        do_write(4'hF);
        check("R5 idle write ptr", rd_ptr, 0);
        check("R5 idle write err", 32'(err), 0);

        do_start(32'h40, 32'h5C, 3);
        check("R1 ready", 32'(ready), 1);
        check("R1 ptr", rd_ptr, 32'h40);
        check("R1 remain", 32'(remain), 3);
        @(negedge clk);
        check("R6 intr set", 32'(intr), 1);

        do_read(mem[8'h10], "R2 first read");
        do_read(mem[8'h10], "R2 repeat read");
        check("R2 ptr held", rd_ptr, 32'h40);

        do_write(4'hF);
        check("R3 ptr", rd_ptr, 32'h44);
        check("R3 remain", 32'(remain), 2);
        do_read(mem[8'h11], "R3 next word");

        do_write(4'h3);
        check("R8 err", 32'(err), 1);
        check("R8 ptr", rd_ptr, 32'h44);
        check("R8 remain", 32'(remain), 2);
        do_read(mem[8'h11], "R8 word kept");

        do_start(32'h100, 32'h1FC, 5);
        check("R10 ptr", rd_ptr, 32'h44);
        check("R10 remain", 32'(remain), 2);

        do_write(4'hF);
        do_write(4'hF);
        check("R4 ready", 32'(ready), 0);
        check("R4 remain", 32'(remain), 0);
        check("R4 ptr", rd_ptr, 32'h4C);
        do_read(0, "R5 read after end");

        check("R6 intr held", 32'(intr), 1);
        @(negedge clk) clr = 1;
        @(negedge clk) clr = 0;
        check("R6 intr cleared", 32'(intr), 0);

        pulse_abort();
        check("R9 err cleared", 32'(err), 0);

        do_start(32'h80, 32'h9C, 0);
        check("R7 empty err", 32'(err), 1);
        check("R7 empty ready", 32'(ready), 0);
        pulse_abort();
        do_start(32'h80, 32'h9C, 9);
        check("R7 oversize err", 32'(err), 1);
        check("R7 oversize ready", 32'(ready), 0);
        pulse_abort();
        do_start(32'h9C, 32'h80, 1);
        check("R7 inverted window err", 32'(err), 1);
        pulse_abort();
        do_start(32'h0, 32'h1FFC, 1025);
        check("R7 above max err", 32'(err), 1);
        check("R7 above max ready", 32'(ready), 0);
        pulse_abort();

        do_start(32'h83, 32'h9F, 8);
        check("R7 exact fit ready", 32'(ready), 1);
        check("R7 exact fit err", 32'(err), 0);
        check("R1 base aligned", rd_ptr, 32'h80);
        @(negedge clk);
        check("R6 intr again", 32'(intr), 1);
        for (int k = 0; k < 7; k++) do_write(4'hF);
        check("R4 one left", 32'(remain), 1);
        do_read(mem[8'h27], "R4 last word");
        do_write(4'hF);
        check("R4 end ready", 32'(ready), 0);
        check("R4 end ptr", rd_ptr, 32'hA0);

        do_start(32'h80, 32'h9C, 4);
        do_write(4'hF);
        pulse_abort();
        check("R9 ready", 32'(ready), 0);
        check("R9 ptr", rd_ptr, 32'h80);
        check("R9 remain", 32'(remain), 0);
        do_read(0, "R9 read after abort");
        do_start(32'h80, 32'h9C, 2);
        do_read(mem[8'h20], "R9 restart first word");

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", 32'(exp_q.size()), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule